// File: doc/BRIEF.md
# Parallel I/O Bus Cycle Decoder

This block sits between an 8-bit processor bus and a two-port parallel I/O controller. On each rising clock edge it samples the chip enable, I/O request, read strobe, machine-cycle-one strobe, the port select line, the command/data select line and the data byte. From these it works out which kind of bus cycle is in progress: a port read, a data write, a command write, an interrupt acknowledge, an instruction fetch, or the special controller reset. A machine-cycle-one strobe with neither read nor I/O request active is that reset.

From the decoded cycle the block raises a one-cycle strobe for each port and each access kind. It also raises a one-cycle pulse when it sees an acknowledge or a reset. It drives an output enable for the tri-state data bus. A small register file stands in for the controller's port registers: a data word and a command word for each port. Data writes and reads go through the data words, so bus traffic can be checked end to end.

The enable is granted for a qualified read, or for an acknowledge that this device wins. When it wins, it presents the supplied interrupt vector.

Top module: `pio_cycle_decoder`

## Requirements
- R1: Control inputs are sampled on the rising clock edge. A strobe appears during the cycle that follows the first edge that samples an access. It lasts exactly one cycle, even if the access is held longer.
- R2: Port select low addresses port A (strobe bit 0). Port select high addresses port B (strobe bit 1).
- R3: The decoder sees a write when chip enable and I/O request are low, and both the read strobe and machine-cycle-one are high. Command/data select high stores the sampled byte in the addressed port's command word and pulses its command strobe. Low stores it in the data word and pulses its data strobe. Bus bit 0 lands in register bit 0.
- R4: The decoder sees a read when chip enable, I/O request and the read strobe are low, and machine-cycle-one is high. It pulses the port's read strobe, whatever command/data select says. It holds the bus enable high with the port's data word on the bus output for every sampled cycle of the read.
- R5: With chip enable high, a write or a read produces no strobe and no bus enable, and leaves the registers unchanged.
- R6: Machine-cycle-one low together with I/O request low is an acknowledge. It pulses the acknowledge output and never a port strobe, even with chip enable low. The vector is driven with the bus enable only if the win input is sampled high.
- R7: Machine-cycle-one low with both the read strobe and I/O request high pulses the reset output. It clears every data and command word and produces no port strobe and no bus enable.
- R8: In every other case the bus enable is low and the bus output is zero. This includes an instruction fetch (machine-cycle-one and read strobe low).
- R9: At most one strobe or pulse output is high in any cycle.
- R10: After the asynchronous reset input is released, all strobes and the bus enable are low and all register words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| m1_n | input | 1 | Machine-cycle-one strobe, active low |
| port_sel | input | SEL_W | Port select, 0 = A, 1 = B |
| cmd_sel | input | 1 | 1 = command byte, 0 = data byte (writes) |
| ack_win | input | 1 | This device owns the acknowledge in progress |
| ack_vector | input | DATA_W | Interrupt vector to present on a won acknowledge |
| bus_in | input | DATA_W | Data byte from the bus |
| bus_out | output | DATA_W | Data byte toward the bus |
| bus_oe | output | 1 | Tri-state enable for bus_out |
| wr_data_stb | output | NPORTS | Per-port data write strobe |
| wr_ctrl_stb | output | NPORTS | Per-port command write strobe |
| rd_data_stb | output | NPORTS | Per-port data read strobe |
| ack_stb | output | 1 | Interrupt acknowledge seen |
| reset_stb | output | 1 | Controller reset condition seen |
| ctrl_words | output | NPORTS*DATA_W | Command words, port A in the low byte |

## Verification
Some properties hold on every cycle, whatever the stimulus, and the assertions check those. At most one strobe or pulse is high at a time, and no port strobe lasts longer than one cycle. A read strobe always comes with the bus enable. A reset pulse never comes with the bus enable, and the cycle after a reset condition shows every register word cleared. An idle bus output is zero.

Some behaviour only shows up when the stored words are read back, and only the bench scenarios can show it. The bench checks that a command and a data byte land in the right port. It checks that cycles with chip enable high leave nothing behind. It checks that an acknowledge with chip enable low does not count as a port access. It checks that the vector appears only when the device wins, and that a held access yields exactly one strobe.

// File: rtl/pio_bus_pkg.sv
package pio_bus_pkg;

   // Decoded bus cycle kind
   typedef enum logic [2:0] {
      ACC_IDLE  = 3'd0,
      ACC_READ  = 3'd1,
      ACC_WDATA = 3'd2,
      ACC_WCTRL = 3'd3,
      ACC_ACK   = 3'd4,
      ACC_RESET = 3'd5,
      ACC_FETCH = 3'd6
   } acc_kind_e;

   // Sampled control strobes, all bus strobes active low
   typedef struct packed {
      logic ce_n;
      logic iorq_n;
      logic rd_n;
      logic m1_n;
      logic cmd_sel;
      logic ack_win;
   } bus_ctl_t;

   localparam int CTL_W = $bits(bus_ctl_t);
   localparam bus_ctl_t CTL_IDLE = '{ce_n: 1'b1, iorq_n: 1'b1, rd_n: 1'b1,
                                     m1_n: 1'b1, cmd_sel: 1'b0, ack_win: 1'b0};

endpackage

// File: rtl/pio_bus_sampler.sv
module pio_bus_sampler
   import pio_bus_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SEL_W     = 1,
   parameter int IN_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_ctl_t          raw_ctl,
   input  logic [SEL_W-1:0]  raw_sel,
   input  logic [DATA_W-1:0] raw_data,
   output bus_ctl_t          s_ctl,
   output logic [SEL_W-1:0]  s_sel,
   output logic [DATA_W-1:0] s_data
);

   localparam int VEC_W = CTL_W + SEL_W + DATA_W;
   localparam logic [VEC_W-1:0] VEC_RST = {CTL_IDLE, {SEL_W{1'b0}}, {DATA_W{1'b0}}};

   if (IN_STAGES < 1 || IN_STAGES > 3) begin : g_bad_stages
      $error("pio_bus_sampler: IN_STAGES must be 1..3");
   end

   logic [VEC_W-1:0] stage_q [IN_STAGES];

   for (genvar i = 0; i < IN_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= VEC_RST;
            else        stage_q[0] <= {raw_ctl, raw_sel, raw_data};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= VEC_RST;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign {s_ctl, s_sel, s_data} = stage_q[IN_STAGES-1];

endmodule

// File: rtl/pio_bus_classifier.sv
module pio_bus_classifier
   import pio_bus_pkg::*;
#(
   parameter int NPORTS = 2,
   parameter int SEL_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_ctl_t          s_ctl,
   input  logic [SEL_W-1:0]  s_sel,
   output logic [NPORTS-1:0] wr_data_stb,
   output logic [NPORTS-1:0] wr_ctrl_stb,
   output logic [NPORTS-1:0] rd_data_stb,
   output logic              ack_stb,
   output logic              reset_stb,
   output logic              reset_level,
   output logic              read_active,
   output logic              ack_drive
);

   localparam int CODE_W = 3 + SEL_W;

   acc_kind_e          kind;
   logic               port_ok;
   logic [SEL_W-1:0]   code_port;
   logic [CODE_W-1:0]  code_now;
   logic [CODE_W-1:0]  code_q;
   logic               first_seen;

   always_comb begin
      kind = ACC_IDLE;
      if (!s_ctl.m1_n && !s_ctl.iorq_n)                  kind = ACC_ACK;
      else if (!s_ctl.m1_n && s_ctl.rd_n && s_ctl.iorq_n) kind = ACC_RESET;
      else if (!s_ctl.m1_n)                               kind = ACC_FETCH;
      else if (!s_ctl.ce_n && !s_ctl.iorq_n) begin
         if (!s_ctl.rd_n)        kind = ACC_READ;
         else if (s_ctl.cmd_sel) kind = ACC_WCTRL;
         else                    kind = ACC_WDATA;
      end
   end

   assign port_ok   = (32'(s_sel) < NPORTS);
   assign code_port = (kind == ACC_READ || kind == ACC_WDATA || kind == ACC_WCTRL)
                      ? s_sel : '0;
   assign code_now  = {kind, code_port};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= {ACC_IDLE, {SEL_W{1'b0}}};
      else        code_q <= code_now;
   end

   assign first_seen = (kind != ACC_IDLE) && (kind != ACC_FETCH) && (code_now != code_q);

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic hit;
      assign hit = first_seen && (s_sel == SEL_W'(p));
      assign wr_data_stb[p] = hit && (kind == ACC_WDATA);
      assign wr_ctrl_stb[p] = hit && (kind == ACC_WCTRL);
      assign rd_data_stb[p] = hit && (kind == ACC_READ);

      // R1
      wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_data_stb[p] || wr_ctrl_stb[p]) |=> !(wr_data_stb[p] || wr_ctrl_stb[p]));
      // R1
      rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_data_stb[p] |=> !rd_data_stb[p]);
   end

   assign ack_stb     = first_seen && (kind == ACC_ACK);
   assign reset_stb   = first_seen && (kind == ACC_RESET);
   assign reset_level = (kind == ACC_RESET);
   assign read_active = (kind == ACC_READ) && port_ok;
   assign ack_drive   = (kind == ACC_ACK) && s_ctl.ack_win;

   // R6
   ack_no_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb |-> (rd_data_stb == '0 && wr_data_stb == '0 && wr_ctrl_stb == '0));

endmodule

// File: rtl/pio_port_regs.sv
module pio_port_regs #(
   parameter int DATA_W     = 8,
   parameter int NPORTS     = 2,
   parameter int SEL_W      = 1,
   parameter bit CLEAR_CTRL = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPORTS-1:0]        wr_data_stb,
   input  logic [NPORTS-1:0]        wr_ctrl_stb,
   input  logic                     clr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [SEL_W-1:0]         rd_sel,
   output logic [DATA_W-1:0]        rd_word,
   output logic [NPORTS*DATA_W-1:0] ctrl_words
);

   logic [DATA_W-1:0] data_q [NPORTS];
   logic [DATA_W-1:0] ctrl_q [NPORTS];

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             data_q[p] <= '0;
         else if (clr)           data_q[p] <= '0;
         else if (wr_data_stb[p]) data_q[p] <= wdata;
      end

      if (CLEAR_CTRL) begin : g_ctrl_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              ctrl_q[p] <= '0;
            else if (clr)            ctrl_q[p] <= '0;
            else if (wr_ctrl_stb[p]) ctrl_q[p] <= wdata;
         end
      end else begin : g_ctrl_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              ctrl_q[p] <= '0;
            else if (wr_ctrl_stb[p]) ctrl_q[p] <= wdata;
         end
      end

      assign ctrl_words[p*DATA_W +: DATA_W] = ctrl_q[p];

      // R7
      clr_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> (data_q[p] == '0));
   end

   always_comb begin
      rd_word = '0;
      for (int p = 0; p < NPORTS; p++) begin
         if (rd_sel == SEL_W'(p)) rd_word = data_q[p];
      end
   end

endmodule

// File: rtl/pio_cycle_decoder.sv
module pio_cycle_decoder
   import pio_bus_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NPORTS     = 2,
   parameter int SEL_W      = (NPORTS > 1) ? $clog2(NPORTS) : 1,
   parameter int IN_STAGES  = 1,
   parameter bit CLEAR_CTRL = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ce_n,
   input  logic                     iorq_n,
   input  logic                     rd_n,
   input  logic                     m1_n,
   input  logic [SEL_W-1:0]         port_sel,
   input  logic                     cmd_sel,
   input  logic                     ack_win,
   input  logic [DATA_W-1:0]        ack_vector,
   input  logic [DATA_W-1:0]        bus_in,
   output logic [DATA_W-1:0]        bus_out,
   output logic                     bus_oe,
   output logic [NPORTS-1:0]        wr_data_stb,
   output logic [NPORTS-1:0]        wr_ctrl_stb,
   output logic [NPORTS-1:0]        rd_data_stb,
   output logic                     ack_stb,
   output logic                     reset_stb,
   output logic [NPORTS*DATA_W-1:0] ctrl_words
);

   if (DATA_W < 1) begin : g_bad_width
      $error("pio_cycle_decoder: DATA_W must be at least 1");
   end
   if (NPORTS < 2) begin : g_bad_ports
      $error("pio_cycle_decoder: NPORTS must be at least 2");
   end
   if ((1 << SEL_W) < NPORTS) begin : g_bad_sel
      $error("pio_cycle_decoder: SEL_W too narrow for NPORTS");
   end

   bus_ctl_t          raw_ctl;
   bus_ctl_t          s_ctl;
   logic [SEL_W-1:0]  s_sel;
   logic [DATA_W-1:0] s_data;
   logic              reset_level;
   logic              read_active;
   logic              ack_drive;
   logic [DATA_W-1:0] rd_word;

   assign raw_ctl = '{ce_n: ce_n, iorq_n: iorq_n, rd_n: rd_n, m1_n: m1_n,
                      cmd_sel: cmd_sel, ack_win: ack_win};

   pio_bus_sampler #(
      .DATA_W(DATA_W), .SEL_W(SEL_W), .IN_STAGES(IN_STAGES)
   ) u_sampler (
      .clk(clk), .rst_n(rst_n),
      .raw_ctl(raw_ctl), .raw_sel(port_sel), .raw_data(bus_in),
      .s_ctl(s_ctl), .s_sel(s_sel), .s_data(s_data)
   );

   pio_bus_classifier #(
      .NPORTS(NPORTS), .SEL_W(SEL_W)
   ) u_classifier (
      .clk(clk), .rst_n(rst_n),
      .s_ctl(s_ctl), .s_sel(s_sel),
      .wr_data_stb(wr_data_stb), .wr_ctrl_stb(wr_ctrl_stb),
      .rd_data_stb(rd_data_stb), .ack_stb(ack_stb), .reset_stb(reset_stb),
      .reset_level(reset_level), .read_active(read_active), .ack_drive(ack_drive)
   );

   pio_port_regs #(
      .DATA_W(DATA_W), .NPORTS(NPORTS), .SEL_W(SEL_W), .CLEAR_CTRL(CLEAR_CTRL)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_data_stb(wr_data_stb), .wr_ctrl_stb(wr_ctrl_stb),
      .clr(reset_level), .wdata(s_data), .rd_sel(s_sel),
      .rd_word(rd_word), .ctrl_words(ctrl_words)
   );

   always_comb begin
      bus_oe  = read_active || ack_drive;
      bus_out = '0;
      if (ack_drive)        bus_out = ack_vector;
      else if (read_active) bus_out = rd_word;
   end

   // R9
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_data_stb, wr_ctrl_stb, rd_data_stb, ack_stb, reset_stb}));
   // R4
   rd_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_stb != '0) |-> bus_oe);
   // R7
   rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_stb |-> !bus_oe);
   // R8
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> (bus_out == '0));

endmodule

// File: tb/pio_cycle_decoder_test.sv
module pio_cycle_decoder_test;

   localparam int CLK_P = 10;
   localparam int DW = 8;
   localparam int NP = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, m1_n = 1'b1;
   logic port_sel = 1'b0, cmd_sel = 1'b0, ack_win = 1'b0;
   logic [DW-1:0] ack_vector = 8'hA5;
   logic [DW-1:0] bus_in = '0;
   logic [DW-1:0] bus_out;
   logic bus_oe;
   logic [NP-1:0] wr_data_stb, wr_ctrl_stb, rd_data_stb;
   logic ack_stb, reset_stb;
   logic [NP*DW-1:0] ctrl_words;

   always #(CLK_P/2) clk = ~clk;

   pio_cycle_decoder uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .iorq_n(iorq_n), .rd_n(rd_n),
      .m1_n(m1_n), .port_sel(port_sel), .cmd_sel(cmd_sel), .ack_win(ack_win),
      .ack_vector(ack_vector), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .wr_data_stb(wr_data_stb), .wr_ctrl_stb(wr_ctrl_stb), .rd_data_stb(rd_data_stb),
      .ack_stb(ack_stb), .reset_stb(reset_stb), .ctrl_words(ctrl_words)
   );

   typedef struct {
      logic [7:0]    ev;
      logic          oe;
      logic [DW-1:0] data;
      string         req;
   } exp_t;

   exp_t exp_q[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   logic [DW-1:0] model_data [NP];
   logic [DW-1:0] model_ctrl [NP];

   function automatic logic [7:0] ev_now();
      return {reset_stb, ack_stb, rd_data_stb, wr_ctrl_stb, wr_data_stb};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor: pops one expected item per observed strobe event
   always @(negedge clk) begin
      if (rst_n && ev_now() != 8'h00) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R5/R9 unexpected strobe", {24'h0, ev_now()}, 32'h0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(ev_now() == e.ev, {e.req, " event"}, {24'h0, ev_now()}, {24'h0, e.ev});
            check(bus_oe == e.oe, {e.req, " bus_oe"}, {31'h0, bus_oe}, {31'h0, e.oe});
            check(bus_out == e.data, {e.req, " bus_out"}, {24'h0, bus_out}, {24'h0, e.data});
         end
      end
   end

   task automatic go_idle();
      ce_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; m1_n = 1'b1;
      cmd_sel = 1'b0; ack_win = 1'b0;
   endtask

   // Drive one cycle for 'hold' clocks; check pulse width and held enable
   task automatic cyc(input logic ce, input logic iorq, input logic rd, input logic m1,
                      input logic sel, input logic cmd, input logic win,
                      input logic [DW-1:0] d, input int hold, input bit has_ev,
                      input exp_t e);
      @(negedge clk);
      ce_n = ce; iorq_n = iorq; rd_n = rd; m1_n = m1;
      port_sel = sel; cmd_sel = cmd; ack_win = win; bus_in = d;
      if (has_ev) exp_q.push_back(e);
      @(negedge clk);
      for (int k = 1; k < hold; k++) begin
         @(negedge clk);
         // R1: only one pulse while the access is held
         check(ev_now() == 8'h00, "R1 pulse width", {24'h0, ev_now()}, 32'h0);
         if (has_ev) begin
            check(bus_oe == e.oe, "R4 held enable", {31'h0, bus_oe}, {31'h0, e.oe});
            check(bus_out == e.data, "R4 held data", {24'h0, bus_out}, {24'h0, e.data});
         end
      end
      go_idle();
   endtask

   task automatic wr(input logic sel, input logic cmd, input logic [DW-1:0] d,
                     input int hold);
      exp_t e;
      e.ev = cmd ? (8'h04 << sel) : (8'h01 << sel);
      e.oe = 1'b0; e.data = '0; e.req = cmd ? "R3 cmd write" : "R3/R2 data write";
      if (cmd) model_ctrl[sel] = d; else model_data[sel] = d;
      cyc(1'b0, 1'b0, 1'b1, 1'b1, sel, cmd, 1'b0, d, hold, 1'b1, e);
   endtask

   task automatic rd(input logic sel, input logic cmd, input int hold, input string req);
      exp_t e;
      e.ev = 8'h10 << sel; e.oe = 1'b1; e.data = model_data[sel]; e.req = req;
      cyc(1'b0, 1'b0, 1'b0, 1'b1, sel, cmd, 1'b0, 8'h00, hold, 1'b1, e);
   endtask

   initial begin
      model_data[0] = '0; model_data[1] = '0;
      model_ctrl[0] = '0; model_ctrl[1] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10
      check(ev_now() == 8'h00 && !bus_oe, "R10 reset outputs", {23'h0, bus_oe, ev_now()}, 32'h0);
      check(ctrl_words == '0, "R10 ctrl words", {16'h0, ctrl_words}, 32'h0);
      rd(1'b0, 1'b0, 1, "R10 read A after reset");

      // R2/R3: data and command writes to each port
      wr(1'b0, 1'b0, 8'h3C, 1);
      wr(1'b1, 1'b0, 8'h81, 3);
      wr(1'b0, 1'b1, 8'h0F, 1);
      wr(1'b1, 1'b1, 8'hF1, 2);
      @(negedge clk);
      check(ctrl_words == {model_ctrl[1], model_ctrl[0]}, "R3 command words",
            {16'h0, ctrl_words}, {16'h0, model_ctrl[1], model_ctrl[0]});
      // R4: reads, cmd_sel ignored on read, held cycles
      rd(1'b0, 1'b0, 3, "R4/R2 read A");
      rd(1'b1, 1'b1, 2, "R4/R2 read B");
      // R3 bit order: single bit 0
      wr(1'b0, 1'b0, 8'h01, 1);
      rd(1'b0, 1'b0, 1, "R3 bit0 lsb");

      // R5: chip enable high, write and read ignored
      begin
         exp_t none;
         none.ev = 0; none.oe = 0; none.data = 0; none.req = "";
         cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hEE, 2, 1'b0, none);
         cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'hEE, 1, 1'b0, none);
         cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1, 1'b0, none);
         check(!bus_oe, "R5 no enable", {31'h0, bus_oe}, 32'h0);
         // R8: instruction fetch, enable stays low
         @(negedge clk);
         ce_n = 1'b0; m1_n = 1'b0; rd_n = 1'b0;
         @(negedge clk);
         check(!bus_oe && bus_out == '0, "R8 fetch idle", {23'h0, bus_oe, bus_out}, 32'h0);
         go_idle();
      end
      check(ctrl_words == {model_ctrl[1], model_ctrl[0]}, "R5 ctrl untouched",
            {16'h0, ctrl_words}, {16'h0, model_ctrl[1], model_ctrl[0]});
      rd(1'b0, 1'b0, 1, "R5 data A untouched");
      rd(1'b1, 1'b0, 1, "R5 data B untouched");

      // R6: acknowledge, won and not won, chip enable low
      begin
         exp_t e;
         e.ev = 8'h40; e.oe = 1'b1; e.data = 8'hA5; e.req = "R6 ack won";
         cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h55, 2, 1'b1, e);
         e.oe = 1'b0; e.data = '0; e.req = "R6 ack lost";
         cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h55, 2, 1'b1, e);
      end
      rd(1'b0, 1'b0, 1, "R6 ack not a write");

      // R7: reset condition
      begin
         exp_t e;
         e.ev = 8'h80; e.oe = 1'b0; e.data = '0; e.req = "R7 reset";
         model_data[0] = '0; model_data[1] = '0;
         model_ctrl[0] = '0; model_ctrl[1] = '0;
         cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 2, 1'b1, e);
      end
      @(negedge clk);
      check(ctrl_words == '0, "R7 ctrl cleared", {16'h0, ctrl_words}, 32'h0);
      rd(1'b0, 1'b0, 1, "R7 data A cleared");
      rd(1'b1, 1'b0, 1, "R7 data B cleared");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R1 missing strobes", exp_q.size(), 32'h0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule